// File: doc/BRIEF.md
# Bank-switched shared memory with mailboxes

This block is a shared word memory that two agents use at the same time. Both agents run on one clock. The storage is split into four equal banks. Each bank is owned by exactly one port at any moment, or by neither port in semaphore mode. Because ownership is exclusive, the two ports never touch the same bank in the same cycle, so the block needs no per-word collision logic.

Ownership comes from one of two sources, chosen by a mode input:
- a four-bit select vector driven by hardware, or
- a set of claim/release semaphores. A port takes a bank by claiming it and hands it back by releasing it.

Each port has its own address, write data, write strobe and byte lanes. A read returns data one cycle after the request. A request to a bank the port does not own does nothing to the memory and raises an error flag.

Two one-word mailboxes carry short messages, one in each direction. A port writes its outgoing box, and this raises an interrupt toward the other port. The interrupt stays up until the receiving port acknowledges it.

Top module: `bsdp_mem`

## Requirements
- R1: The two most significant address bits select the bank (0 to 3). The remaining bits select the word inside that bank. A word written by the owning port is returned by a later read of the same address.
- R2: A read request accepted at a clock edge presents its data on the port's read output after that edge, one cycle of latency. In the cycle after any request that is not an owned read, the read output is zero.
- R3: Byte enable bit k gates data bits [8k+7:8k] of a write. Lanes whose enable bit is 0 keep their old contents.
- R4: When own_mode is 0, bank i belongs to port B if hw_sel[i] is 1 and to port A if it is 0.
- R5: An access to a bank the port does not own is blocked:
  - a blocked write leaves the memory unchanged;
  - a blocked read returns zero;
  - the port's error output is 1 for exactly the cycle after the request.
- R6: When own_mode is 1, a claim of bank i succeeds only if no port holds that bank. The held output shows the new state after the next clock edge. A claim of a bank held by the other port has no effect.
- R7: A release takes effect at the next edge, and only when it comes from the holder. A release from the port that does not hold the bank is ignored.
- R8: If both ports claim the same free bank in the same cycle, port A gets it.
- R9: When own_mode is 1, a port owns exactly the banks it holds. A bank held by nobody blocks both ports.
- R10: Port A writing its outgoing mailbox does two things after the next edge: b_mbx_data shows a_wdata, and b_irq is set. A b_mbx_ack clears b_irq. If a write and an ack arrive in the same cycle, the write wins.
- R11: The same rules apply from B to A: b_mbx_wr stores b_wdata into a_mbx_data and sets a_irq, and a_mbx_ack clears a_irq.
- R12: After reset the following are all zero: both semaphore sets, both interrupts, both mailboxes, both error outputs and both read outputs.
- R13: No bank is ever held by both ports at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| own_mode | input | 1 | 0: ownership from hw_sel; 1: ownership from semaphores |
| hw_sel | input | 4 | Per-bank owner in mode 0 (1 = port B) |
| a_en | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_be | input | DATA_W/8 | Port A byte lanes |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data and mailbox data |
| a_rdata | output | DATA_W | Port A read data |
| a_err | output | 1 | Port A blocked-access flag |
| b_en | input | 1 | Port B access request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_be | input | DATA_W/8 | Port B byte lanes |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data and mailbox data |
| b_rdata | output | DATA_W | Port B read data |
| b_err | output | 1 | Port B blocked-access flag |
| a_sem_claim | input | 4 | Port A per-bank claim |
| a_sem_rel | input | 4 | Port A per-bank release |
| a_sem_held | output | 4 | Banks held by port A |
| b_sem_claim | input | 4 | Port B per-bank claim |
| b_sem_rel | input | 4 | Port B per-bank release |
| b_sem_held | output | 4 | Banks held by port B |
| a_mbx_wr | input | 1 | Port A writes its outgoing mailbox |
| a_mbx_ack | input | 1 | Port A acknowledges its incoming mailbox |
| a_mbx_data | output | DATA_W | Message from port B |
| a_irq | output | 1 | Message waiting for port A |
| b_mbx_wr | input | 1 | Port B writes its outgoing mailbox |
| b_mbx_ack | input | 1 | Port B acknowledges its incoming mailbox |
| b_mbx_data | output | DATA_W | Message from port A |
| b_irq | output | 1 | Message waiting for port B |

## Verification
The properties assume three things about the inputs:
- no traffic arrives during the two cycles in which the internal reset is still held after rst_n rises;
- own_mode and hw_sel stay steady across any request they govern;
- a port's claim, release and mailbox strobes are single-cycle pulses that are sampled at an edge.

The stimulus keeps to these assumptions in the following ways. It changes inputs only on the falling edge. It waits several cycles after reset before sending anything. It sets the mode and select vector before each phase and does not change them while that phase's requests are in flight. Each request is a one-cycle pulse followed by an idle cycle, so every response is sampled in isolation.

// File: rtl/bsdp_pkg.sv
package bsdp_pkg;
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned BANK_W    = 2;

  typedef enum logic {
    OWN_PIN = 1'b0,
    OWN_SEM = 1'b1
  } own_mode_e;
endpackage

// File: rtl/bsdp_sem.sv
module bsdp_sem #(
  parameter int unsigned NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] a_claim,
  input  logic [NB-1:0] a_rel,
  input  logic [NB-1:0] b_claim,
  input  logic [NB-1:0] b_rel,
  output logic [NB-1:0] held_a,
  output logic [NB-1:0] held_b
);
  logic [NB-1:0] held_a_d, held_b_d;

  for (genvar i = 0; i < NB; i++) begin : g_sem
    always_comb begin
      held_a_d[i] = held_a[i];
      held_b_d[i] = held_b[i];
      if (held_a[i]) begin
        held_a_d[i] = ~a_rel[i];
      end else if (held_b[i]) begin
        held_b_d[i] = ~b_rel[i];
      end else begin
        // free bank: port A has precedence on a tie
        held_a_d[i] = a_claim[i];
        held_b_d[i] = ~a_claim[i] & b_claim[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_a <= '0;
      held_b <= '0;
    end else begin
      held_a <= held_a_d;
      held_b <= held_b_d;
    end
  end
endmodule

// File: rtl/bsdp_bank.sv
module bsdp_bank #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                en,
  input  logic                we,
  input  logic [DATA_W/8-1:0] be,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_en, rd_en;

  always_comb begin
    wr_en = en & we;
    rd_en = en & ~we;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && be[k]) begin
        mem[idx][k*8 +: 8] <= wdata[k*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rdata <= mem[idx];
    end
  end
endmodule

// File: rtl/bsdp_port.sv
module bsdp_port #(
  parameter int unsigned NB     = 4,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [BANK_W-1:0] bank,
  input  logic [NB-1:0]     own,
  input  logic [NB*DATA_W-1:0] bank_rdata,
  output logic [NB-1:0]     hit,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  logic              ok;
  logic              rd_d, rd_q;
  logic              err_d, err_q;
  logic [BANK_W-1:0] bank_q;

  for (genvar i = 0; i < NB; i++) begin : g_hit
    always_comb hit[i] = en && (bank == BANK_W'(i)) && own[i];
  end

  always_comb begin
    ok    = |hit;
    rd_d  = ok & ~we;
    err_d = en & ~ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      err_q  <= 1'b0;
      bank_q <= '0;
    end else begin
      rd_q  <= rd_d;
      err_q <= err_d;
      if (en) begin
        bank_q <= bank;
      end
    end
  end

  always_comb begin
    rdata = rd_q ? bank_rdata[bank_q*DATA_W +: DATA_W] : '0;
    err   = err_q;
  end
endmodule

// File: rtl/bsdp_mbox.sv
module bsdp_mbox #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack,
  output logic [DATA_W-1:0] data,
  output logic              irq
);
  logic irq_d;

  always_comb begin
    irq_d = irq;
    if (ack) irq_d = 1'b0;
    if (wr)  irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      irq  <= 1'b0;
    end else begin
      irq <= irq_d;
      if (wr) begin
        data <= wdata;
      end
    end
  end
endmodule

// File: rtl/bsdp_mem.sv
module bsdp_mem
  import bsdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                own_mode,
  input  logic [3:0]          hw_sel,
  input  logic                a_en,
  input  logic                a_we,
  input  logic [DATA_W/8-1:0] a_be,
  input  logic [ADDR_W-1:0]   a_addr,
  input  logic [DATA_W-1:0]   a_wdata,
  output logic [DATA_W-1:0]   a_rdata,
  output logic                a_err,
  input  logic                b_en,
  input  logic                b_we,
  input  logic [DATA_W/8-1:0] b_be,
  input  logic [ADDR_W-1:0]   b_addr,
  input  logic [DATA_W-1:0]   b_wdata,
  output logic [DATA_W-1:0]   b_rdata,
  output logic                b_err,
  input  logic [3:0]          a_sem_claim,
  input  logic [3:0]          a_sem_rel,
  output logic [3:0]          a_sem_held,
  input  logic [3:0]          b_sem_claim,
  input  logic [3:0]          b_sem_rel,
  output logic [3:0]          b_sem_held,
  input  logic                a_mbx_wr,
  input  logic                a_mbx_ack,
  output logic [DATA_W-1:0]   a_mbx_data,
  output logic                a_irq,
  input  logic                b_mbx_wr,
  input  logic                b_mbx_ack,
  output logic [DATA_W-1:0]   b_mbx_data,
  output logic                b_irq
);
  localparam int unsigned NB    = NUM_BANKS;
  localparam int unsigned IDX_W = ADDR_W - BANK_W;
  localparam int unsigned LANES = DATA_W / 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  always_comb rst_n_i = rst_sync[1];

  // ownership
  logic [NB-1:0] own_a, own_b;
  own_mode_e     mode;

  always_comb begin
    mode = own_mode_e'(own_mode);
    if (mode == OWN_SEM) begin
      own_a = a_sem_held;
      own_b = b_sem_held;
    end else begin
      own_a = ~hw_sel;
      own_b = hw_sel;
    end
  end

  bsdp_sem #(.NB(NB)) u_sem (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .a_claim(a_sem_claim),
    .a_rel  (a_sem_rel),
    .b_claim(b_sem_claim),
    .b_rel  (b_sem_rel),
    .held_a (a_sem_held),
    .held_b (b_sem_held)
  );

  // port front ends
  logic [NB-1:0]        hit_a, hit_b;
  logic [NB*DATA_W-1:0] bank_rdata;

  bsdp_port #(.NB(NB), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_port_a (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .en        (a_en),
    .we        (a_we),
    .bank      (a_addr[ADDR_W-1 -: BANK_W]),
    .own       (own_a),
    .bank_rdata(bank_rdata),
    .hit       (hit_a),
    .rdata     (a_rdata),
    .err       (a_err)
  );

  bsdp_port #(.NB(NB), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_port_b (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .en        (b_en),
    .we        (b_we),
    .bank      (b_addr[ADDR_W-1 -: BANK_W]),
    .own       (own_b),
    .bank_rdata(bank_rdata),
    .hit       (hit_b),
    .rdata     (b_rdata),
    .err       (b_err)
  );

  // banks: each takes the single port that owns it
  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic              bk_en, bk_we;
    logic [LANES-1:0]  bk_be;
    logic [IDX_W-1:0]  bk_idx;
    logic [DATA_W-1:0] bk_wdata, bk_rdata;

    always_comb begin
      bk_en = hit_a[i] | hit_b[i];
      if (hit_b[i]) begin
        bk_we    = b_we;
        bk_be    = b_be;
        bk_idx   = b_addr[IDX_W-1:0];
        bk_wdata = b_wdata;
      end else begin
        bk_we    = a_we;
        bk_be    = a_be;
        bk_idx   = a_addr[IDX_W-1:0];
        bk_wdata = a_wdata;
      end
    end

    bsdp_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
      .clk  (clk),
      .en   (bk_en),
      .we   (bk_we),
      .be   (bk_be),
      .idx  (bk_idx),
      .wdata(bk_wdata),
      .rdata(bk_rdata)
    );

    always_comb bank_rdata[i*DATA_W +: DATA_W] = bk_rdata;
  end

  // mailboxes
  bsdp_mbox #(.DATA_W(DATA_W)) u_mbx_ab (
    .clk  (clk),
    .rst_n(rst_n_i),
    .wr   (a_mbx_wr),
    .wdata(a_wdata),
    .ack  (b_mbx_ack),
    .data (b_mbx_data),
    .irq  (b_irq)
  );

  bsdp_mbox #(.DATA_W(DATA_W)) u_mbx_ba (
    .clk  (clk),
    .rst_n(rst_n_i),
    .wr   (b_mbx_wr),
    .wdata(b_wdata),
    .ack  (a_mbx_ack),
    .data (a_mbx_data),
    .irq  (a_irq)
  );
endmodule

// File: rtl/bsdp_mem_chk.sv
module bsdp_mem_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              own_mode,
  input logic [3:0]        hw_sel,
  input logic              a_en,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_rdata,
  input logic              a_err,
  input logic              b_en,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_err,
  input logic [3:0]        a_sem_claim,
  input logic [3:0]        a_sem_rel,
  input logic [3:0]        a_sem_held,
  input logic [3:0]        b_sem_held,
  input logic              a_mbx_wr,
  input logic              a_mbx_ack,
  input logic              a_irq,
  input logic              b_mbx_wr,
  input logic              b_mbx_ack,
  input logic              b_irq
);
  a_r13_sem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sem_held & b_sem_held) == 4'b0000);

  a_r6_gain_needs_free_claim: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((a_sem_held & ~$past(a_sem_held) & ($past(b_sem_held) | ~$past(a_sem_claim))) == 4'b0000));

  a_r7_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(a_sem_held & ~a_sem_rel) & ~a_sem_held) == 4'b0000));

  a_r8_a_wins_tie: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((b_sem_held & $past(a_sem_claim & ~a_sem_held & ~b_sem_held)) == 4'b0000));

  a_r4_pin_block_a: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !own_mode && hw_sel[a_addr[ADDR_W-1 -: 2]]) |=> a_err);

  a_r4_pin_block_b: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && !own_mode && !hw_sel[b_addr[ADDR_W-1 -: 2]]) |=> b_err);

  a_r5_err_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    a_err |-> (a_rdata == '0));

  a_r5_err_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    b_err |-> (b_rdata == '0));

  a_r10_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    a_mbx_wr |=> b_irq);

  a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (b_mbx_ack && !a_mbx_wr) |=> !b_irq);

  a_r11_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    b_mbx_wr |=> a_irq);

  a_r11_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mbx_ack && !b_mbx_wr) |=> !a_irq);
endmodule

bind bsdp_mem bsdp_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .own_mode   (own_mode),
  .hw_sel     (hw_sel),
  .a_en       (a_en),
  .a_addr     (a_addr),
  .a_rdata    (a_rdata),
  .a_err      (a_err),
  .b_en       (b_en),
  .b_addr     (b_addr),
  .b_rdata    (b_rdata),
  .b_err      (b_err),
  .a_sem_claim(a_sem_claim),
  .a_sem_rel  (a_sem_rel),
  .a_sem_held (a_sem_held),
  .b_sem_held (b_sem_held),
  .a_mbx_wr   (a_mbx_wr),
  .a_mbx_ack  (a_mbx_ack),
  .a_irq      (a_irq),
  .b_mbx_wr   (b_mbx_wr),
  .b_mbx_ack  (b_mbx_ack),
  .b_irq      (b_irq)
);

// File: tb/bsdp_mem_bench.sv
module bsdp_mem_bench;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        own_mode;
  logic [3:0]  hw_sel;
  logic        a_en, a_we, b_en, b_we;
  logic [3:0]  a_be, b_be;
  logic [7:0]  a_addr, b_addr;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic        a_err, b_err;
  logic [3:0]  a_sem_claim, a_sem_rel, a_sem_held;
  logic [3:0]  b_sem_claim, b_sem_rel, b_sem_held;
  logic        a_mbx_wr, a_mbx_ack, a_irq, b_mbx_wr, b_mbx_ack, b_irq;
  logic [31:0] a_mbx_data, b_mbx_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bsdp_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bsdp_mem (.*);

  typedef struct packed {
    logic        pb;
    logic        we;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  // pin mode, hw_sel = 4'b1010: banks 0,2 -> A, banks 1,3 -> B
  localparam vec_t VEC [14] = '{
    '{1'b0, 1'b1, 8'h05, 4'hF, 32'h11223344, 32'h0,        1'b0, 4'd1},  // R1 write bank0
    '{1'b0, 1'b0, 8'h05, 4'hF, 32'h0,        32'h11223344, 1'b0, 4'd2},  // R2 read back
    '{1'b1, 1'b1, 8'h45, 4'hF, 32'hAABBCCDD, 32'h0,        1'b0, 4'd4},  // R4 B owns bank1
    '{1'b1, 1'b0, 8'h45, 4'hF, 32'h0,        32'hAABBCCDD, 1'b0, 4'd4},  // R4
    '{1'b0, 1'b1, 8'h05, 4'h5, 32'h99887766, 32'h0,        1'b0, 4'd3},  // R3 lanes 0,2
    '{1'b0, 1'b0, 8'h05, 4'hF, 32'h0,        32'h11883366, 1'b0, 4'd3},  // R3 merged word
    '{1'b0, 1'b0, 8'h45, 4'hF, 32'h0,        32'h0,        1'b1, 4'd5},  // R5 blocked read
    '{1'b0, 1'b1, 8'h45, 4'hF, 32'hDEADBEEF, 32'h0,        1'b1, 4'd5},  // R5 blocked write
    '{1'b1, 1'b0, 8'h45, 4'hF, 32'h0,        32'hAABBCCDD, 1'b0, 4'd5},  // R5 write dropped
    '{1'b1, 1'b0, 8'h05, 4'hF, 32'h0,        32'h0,        1'b1, 4'd4},  // R4 B blocked on bank0
    '{1'b0, 1'b1, 8'h80, 4'hF, 32'h0BADF00D, 32'h0,        1'b0, 4'd1},  // R1 bank2
    '{1'b0, 1'b0, 8'h80, 4'hF, 32'h0,        32'h0BADF00D, 1'b0, 4'd1},  // R1
    '{1'b1, 1'b1, 8'hFF, 4'hF, 32'h12345678, 32'h0,        1'b0, 4'd1},  // R1 bank3 top word
    '{1'b1, 1'b0, 8'hFF, 4'hF, 32'h0,        32'h12345678, 1'b0, 4'd1}   // R1
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    a_en = 0; a_we = 0; a_be = 0; a_addr = 0; a_wdata = 0;
    b_en = 0; b_we = 0; b_be = 0; b_addr = 0; b_wdata = 0;
    a_sem_claim = 0; a_sem_rel = 0; b_sem_claim = 0; b_sem_rel = 0;
    a_mbx_wr = 0; a_mbx_ack = 0; b_mbx_wr = 0; b_mbx_ack = 0;
  endtask

  task automatic access(input logic pb, input logic we, input logic [7:0] addr,
                        input logic [3:0] be, input logic [31:0] wd);
    if (pb) begin b_en = 1; b_we = we; b_addr = addr; b_be = be; b_wdata = wd; end
    else    begin a_en = 1; a_we = we; a_addr = addr; a_be = be; a_wdata = wd; end
    @(negedge clk);
    idle();
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    own_mode = 1'b0;
    hw_sel   = 4'b1010;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12", "sem held A", {28'b0, a_sem_held}, 32'h0);
    chk("R12", "sem held B", {28'b0, b_sem_held}, 32'h0);
    chk("R12", "irqs", {30'b0, a_irq, b_irq}, 32'h0);
    chk("R12", "mailbox B", b_mbx_data, 32'h0);
    chk("R12", "errs/rdata", a_rdata | b_rdata | {30'b0, a_err, b_err}, 32'h0);

    // vector table, pin ownership
    foreach (VEC[i]) begin
      access(VEC[i].pb, VEC[i].we, VEC[i].addr, VEC[i].be, VEC[i].wd);
      chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d rdata", i),
          VEC[i].pb ? b_rdata : a_rdata, VEC[i].exp_rd);
      chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d err", i),
          {31'b0, VEC[i].pb ? b_err : a_err}, {31'b0, VEC[i].exp_err});
      step();
      chk("R5", "err lasts one cycle", {30'b0, a_err, b_err}, 32'h0);
    end

    // semaphore ownership
    own_mode = 1'b1;
    access(1'b0, 1'b0, 8'h05, 4'hF, 32'h0);
    chk("R9", "unheld bank blocks A", {31'b0, a_err}, 32'h1);
    a_sem_claim = 4'b0001; step();
    chk("R6", "A claims bank0", {28'b0, a_sem_held}, 32'h1);
    b_sem_claim = 4'b0001; step();
    chk("R6", "B claim of held bank", {28'b0, b_sem_held}, 32'h0);
    a_sem_claim = 4'b0100; b_sem_claim = 4'b0100; step();
    chk("R8", "tie to A", {28'b0, a_sem_held}, 32'h5);
    chk("R8", "tie B loses", {28'b0, b_sem_held}, 32'h0);
    b_sem_rel = 4'b0001; step();
    chk("R7", "foreign release ignored", {28'b0, a_sem_held}, 32'h5);
    access(1'b0, 1'b0, 8'h05, 4'hF, 32'h0);
    chk("R9", "A reads held bank0", a_rdata, 32'h11883366);
    b_sem_claim = 4'b0010; step();
    access(1'b1, 1'b0, 8'h45, 4'hF, 32'h0);
    chk("R9", "B reads held bank1", b_rdata, 32'hAABBCCDD);
    access(1'b1, 1'b0, 8'h05, 4'hF, 32'h0);
    chk("R9", "B blocked on A bank", {31'b0, b_err}, 32'h1);
    a_sem_rel = 4'b0001; step();
    chk("R7", "A release bank0", {28'b0, a_sem_held}, 32'h4);
    b_sem_claim = 4'b0001; step();
    chk("R6", "B claims freed bank0", {28'b0, b_sem_held}, 32'h3);
    chk("R13", "no shared bank", {28'b0, a_sem_held & b_sem_held}, 32'h0);

    // mailboxes
    a_mbx_wr = 1; a_wdata = 32'hCAFE0001; step();
    chk("R10", "b_irq set", {31'b0, b_irq}, 32'h1);
    chk("R10", "b_mbx_data", b_mbx_data, 32'hCAFE0001);
    chk("R10", "a_irq untouched", {31'b0, a_irq}, 32'h0);
    b_mbx_ack = 1; step();
    chk("R10", "ack clears b_irq", {31'b0, b_irq}, 32'h0);
    a_mbx_wr = 1; a_wdata = 32'hCAFE0002; b_mbx_ack = 1; step();
    chk("R10", "write beats ack", {31'b0, b_irq}, 32'h1);
    b_mbx_wr = 1; b_wdata = 32'hBEEF0003; step();
    chk("R11", "a_irq set", {31'b0, a_irq}, 32'h1);
    chk("R11", "a_mbx_data", a_mbx_data, 32'hBEEF0003);
    a_mbx_ack = 1; step();
    chk("R11", "ack clears a_irq", {31'b0, a_irq}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule